// File: doc/BRIEF.md
# Pulse-Count Remote Command Decoder

This block turns the demodulated carrier-present signal of a toy remote-control transmitter into drive commands. The transmitter sends a frame made of a preamble of four long pulses, then a run of short pulses. The number of short pulses selects the command. The block resynchronises the incoming level and removes single-sample glitches. It then measures every high interval in ticks of an internal prescaler and sorts each one as long, short or invalid. A line that stays low past a timeout marks the end of a frame, and the block checks the short-pulse count against the five legal values.

The decoder is built around four named states. IDLE waits for a first long pulse (transition start). PREAMBLE counts long pulses and moves to COUNT when a short pulse follows exactly four longs (transition enter_run). It returns to IDLE on a fifth long, on a short after too few longs, on an invalid width, or on a timeout (transition abort). COUNT tallies short pulses. It returns to IDLE on a long or invalid pulse (abort) and goes to DONE on a timeout (transition close). DONE lasts one cycle and always returns to IDLE (transition report). During that cycle the count is compared, and the result shows on the outputs on the next cycle.

Top module: `ook_cmd_decoder`

## Requirements
- R1: A one-clock high spike within a low gap, or a one-clock low drop within a pulse, has no effect on the decoded command.
- R2: A high interval counts as long when it lasts LONG_MIN to LONG_MAX whole ticks (11..19 by default) and as short when it lasts SHORT_MIN to SHORT_MAX whole ticks (3..7). Any other width, for example 10, 20, 2 or 8 ticks, abandons the frame and produces no strobe.
- R3: A frame needs exactly PRE_LEN (4) long pulses before its first short pulse. Three longs, or five, abandon the frame with no strobe.
- R4: A frame ends only when the line stays low for more than GAP_TIMEOUT (20) ticks. A low gap of 19 ticks inside a frame keeps the frame going, and no strobe appears before the timeout expires.
- R5: On a frame's end, the short-pulse count is mapped to cmd_code as follows: 4 gives 0 (stop), 10 gives 1 (forward), 40 gives 2 (reverse), 58 gives 3 (turn left) and 64 gives 4 (turn right). cmd_valid is raised for that one cycle.
- R6: A completed frame whose count is not one of those five values raises cmd_err for one cycle instead of cmd_valid.
- R7: cmd_valid and cmd_err are never high together, and each lasts exactly one cycle per frame.
- R8: After reset, cmd_valid and cmd_err are low and cmd_code is 0.
- R9: cmd_code changes only in a cycle where cmd_valid is high. It holds its value through error frames and abandoned frames.
- R10: A long pulse that arrives after the short run has started abandons the frame with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_in | input | 1 | Demodulated carrier level, asynchronous to clk |
| cmd_valid | output | 1 | One-cycle strobe for a recognised command |
| cmd_err | output | 1 | One-cycle strobe for a frame with an unknown count |
| cmd_code | output | 3 | Last recognised command, 0..4 |

## Verification
A wrong state or counter in the decoder only shows up at the end of a frame. The wrong strobe appears, or no strobe appears, or the code is wrong, one cycle after the timeout closes the frame. The bench therefore checks the strobe counts and the code after every frame's trailing gap. For the timeout itself, it also samples partway through the closing gap, to catch a frame that closes too early. A miscounted preamble or a misclassified width turns an intended command into silence, so the boundary widths are sent exactly at and just beyond each limit.

// File: rtl/ook_pkg.sv
package ook_pkg;

    typedef enum logic [1:0] {
        PK_LONG  = 2'd0,
        PK_SHORT = 2'd1,
        PK_BAD   = 2'd2
    } pulse_kind_t;

    typedef enum logic [2:0] {
        CMD_STOP  = 3'd0,
        CMD_FWD   = 3'd1,
        CMD_BACK  = 3'd2,
        CMD_LEFT  = 3'd3,
        CMD_RIGHT = 3'd4
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_COUNT    = 2'd2,
        ST_DONE     = 2'd3
    } dec_state_t;

    localparam int unsigned CNT_STOP  = 4;
    localparam int unsigned CNT_FWD   = 10;
    localparam int unsigned CNT_BACK  = 40;
    localparam int unsigned CNT_LEFT  = 58;
    localparam int unsigned CNT_RIGHT = 64;

endpackage

// File: rtl/ook_line_filter.sv
module ook_line_filter #(
    parameter int unsigned SYNC_LEN = 2,
    parameter int unsigned VOTE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    localparam int unsigned HALF = VOTE_LEN / 2;

    logic [SYNC_LEN-1:0] sync_q;
    logic [VOTE_LEN-1:0] win_q;

    // Synchroniser chain for the asynchronous line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], din};
        end
    end

    // Sliding window of synchronised samples and majority vote
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            lvl   <= 1'b0;
        end else begin
            win_q <= {win_q[VOTE_LEN-2:0], sync_q[SYNC_LEN-1]};
            lvl   <= (32'($countones(win_q)) > HALF);
        end
    end

endmodule

// File: rtl/ook_tick_gen.sv
module ook_tick_gen #(
    parameter int unsigned DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    assign tick = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/ook_width_meter.sv
module ook_width_meter
    import ook_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned LONG_MIN    = 11,
    parameter int unsigned LONG_MAX    = 19,
    parameter int unsigned SHORT_MIN   = 3,
    parameter int unsigned SHORT_MAX   = 7,
    parameter int unsigned GAP_TIMEOUT = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lvl,
    input  logic        tick,
    output logic        edge_seen,
    output logic        pulse_evt,
    output pulse_kind_t pulse_kind,
    output logic        gap_to
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    logic             lvl_q;
    logic [CNT_W-1:0] run_q;
    pulse_kind_t      kind_now;

    assign edge_seen = lvl ^ lvl_q;

    // Classify the completed high interval
    always_comb begin
        if (32'(run_q) >= LONG_MIN && 32'(run_q) <= LONG_MAX) begin
            kind_now = PK_LONG;
        end else if (32'(run_q) >= SHORT_MIN && 32'(run_q) <= SHORT_MAX) begin
            kind_now = PK_SHORT;
        end else begin
            kind_now = PK_BAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q      <= 1'b0;
            run_q      <= '0;
            pulse_evt  <= 1'b0;
            pulse_kind <= PK_BAD;
            gap_to     <= 1'b0;
        end else begin
            lvl_q      <= lvl;
            pulse_evt  <= lvl_q & ~lvl;
            pulse_kind <= kind_now;
            gap_to     <= ~lvl & ~edge_seen & tick & (32'(run_q) == GAP_TIMEOUT);
            if (edge_seen) begin
                run_q <= '0;
            end else if (tick && run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ook_cmd_decoder.sv
module ook_cmd_decoder
    import ook_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 10000,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned LONG_MIN    = 11,
    parameter int unsigned LONG_MAX    = 19,
    parameter int unsigned SHORT_MIN   = 3,
    parameter int unsigned SHORT_MAX   = 7,
    parameter int unsigned GAP_TIMEOUT = 20,
    parameter int unsigned PRE_LEN     = 4,
    parameter int unsigned SHORT_CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rf_in,
    output logic       cmd_valid,
    output logic       cmd_err,
    output logic [2:0] cmd_code
);
    localparam int unsigned LONG_W = $clog2(PRE_LEN + 1);
    localparam logic [SHORT_CNT_W-1:0] SHORT_SAT = '1;

    logic        lvl;
    logic        tick;
    logic        edge_seen;
    logic        pulse_evt;
    pulse_kind_t pulse_kind;
    logic        gap_to;

    dec_state_t             state, state_n;
    logic [LONG_W-1:0]      longs, longs_n;
    logic [SHORT_CNT_W-1:0] shorts, shorts_n;
    logic                   hit;
    cmd_t                   hit_code;

    ook_line_filter #(.SYNC_LEN(2), .VOTE_LEN(3)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rf_in),
        .lvl   (lvl)
    );

    ook_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (edge_seen),
        .tick    (tick)
    );

    ook_width_meter #(
        .CNT_W       (CNT_W),
        .LONG_MIN    (LONG_MIN),
        .LONG_MAX    (LONG_MAX),
        .SHORT_MIN   (SHORT_MIN),
        .SHORT_MAX   (SHORT_MAX),
        .GAP_TIMEOUT (GAP_TIMEOUT)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .tick       (tick),
        .edge_seen  (edge_seen),
        .pulse_evt  (pulse_evt),
        .pulse_kind (pulse_kind),
        .gap_to     (gap_to)
    );

    // Next-state logic
    always_comb begin
        state_n  = state;
        longs_n  = longs;
        shorts_n = shorts;
        unique case (state)
            ST_IDLE: begin
                if (pulse_evt && pulse_kind == PK_LONG) begin
                    state_n  = ST_PREAMBLE;
                    longs_n  = LONG_W'(1);
                    shorts_n = '0;
                end
            end
            ST_PREAMBLE: begin
                if (pulse_evt) begin
                    if (pulse_kind == PK_LONG) begin
                        if (longs == LONG_W'(PRE_LEN)) begin
                            state_n = ST_IDLE;
                        end else begin
                            longs_n = longs + 1'b1;
                        end
                    end else if (pulse_kind == PK_SHORT && longs == LONG_W'(PRE_LEN)) begin
                        state_n  = ST_COUNT;
                        shorts_n = SHORT_CNT_W'(1);
                    end else begin
                        state_n = ST_IDLE;
                    end
                end else if (gap_to) begin
                    state_n = ST_IDLE;
                end
            end
            ST_COUNT: begin
                if (pulse_evt) begin
                    if (pulse_kind == PK_SHORT) begin
                        if (shorts != SHORT_SAT) begin
                            shorts_n = shorts + 1'b1;
                        end
                    end else begin
                        state_n = ST_IDLE;
                    end
                end else if (gap_to) begin
                    state_n = ST_DONE;
                end
            end
            ST_DONE: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            longs  <= '0;
            shorts <= '0;
        end else begin
            state  <= state_n;
            longs  <= longs_n;
            shorts <= shorts_n;
        end
    end

    // Count-to-command lookup
    always_comb begin
        hit      = 1'b1;
        hit_code = CMD_STOP;
        if (32'(shorts) == CNT_STOP) begin
            hit_code = CMD_STOP;
        end else if (32'(shorts) == CNT_FWD) begin
            hit_code = CMD_FWD;
        end else if (32'(shorts) == CNT_BACK) begin
            hit_code = CMD_BACK;
        end else if (32'(shorts) == CNT_LEFT) begin
            hit_code = CMD_LEFT;
        end else if (32'(shorts) == CNT_RIGHT) begin
            hit_code = CMD_RIGHT;
        end else begin
            hit = 1'b0;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_code  <= CMD_STOP;
        end else begin
            cmd_valid <= (state == ST_DONE) && hit;
            cmd_err   <= (state == ST_DONE) && !hit;
            if (state == ST_DONE && hit) begin
                cmd_code <= hit_code;
            end
        end
    end

endmodule

// File: rtl/ook_cmd_decoder_chk.sv
module ook_cmd_decoder_chk
    import ook_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_err,
    input logic [2:0] cmd_code,
    input dec_state_t state,
    input logic       gap_to
);

    p_excl_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_err));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err);

    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_code));

    p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code <= 3'd4));

    p_strobe_from_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || cmd_err) |-> ($past(state) == ST_DONE));

    p_done_on_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> $past(gap_to));

endmodule

bind ook_cmd_decoder ook_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_err   (cmd_err),
    .cmd_code  (cmd_code),
    .state     (state),
    .gap_to    (gap_to)
);

// File: tb/sim_ook_cmd_decoder.sv
module sim_ook_cmd_decoder;

    localparam int DIV = 4;
    localparam int IGN = -2;
    localparam int ERR = -1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rf_in = 1'b0;
    logic       cmd_valid;
    logic       cmd_err;
    logic [2:0] cmd_code;

    int n_chk = 0;
    int n_fail = 0;
    int nv = 0;
    int ne = 0;
    int n_both = 0;
    int n_run = 0;
    int last_code = 0;
    int model_code = 0;
    bit prev_valid = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ook_cmd_decoder #(.TICK_DIV(DIV)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rf_in     (rf_in),
        .cmd_valid (cmd_valid),
        .cmd_err   (cmd_err),
        .cmd_code  (cmd_code)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                nv++;
                last_code = int'(cmd_code);
            end
            if (cmd_err) ne++;
            if (cmd_valid && cmd_err) n_both++;
            if (cmd_valid && prev_valid) n_run++;
            prev_valid = cmd_valid;
        end
    end

    function automatic int exp_code(int n);
        case (n)
            4:  return 0;
            10: return 1;
            40: return 2;
            58: return 3;
            64: return 4;
            default: return ERR;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic drive(bit v, int clocks);
        rf_in = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic pulse(int hi_t, int lo_t);
        drive(1'b1, hi_t * DIV + DIV / 2);
        drive(1'b0, lo_t * DIV + DIV / 2);
    endtask

    task automatic pulse_glitch(int hi_t, int lo_t);
        drive(1'b1, 3);
        drive(1'b0, 1);
        drive(1'b1, hi_t * DIV + DIV / 2 - 4);
        drive(1'b0, 3);
        drive(1'b1, 1);
        drive(1'b0, lo_t * DIV + DIV / 2 - 4);
    endtask

    task automatic clear_mon();
        nv = 0;
        ne = 0;
    endtask

    task automatic close_frame();
        drive(1'b0, 30 * DIV);
    endtask

    task automatic expect_frame(string req, int expv);
        if (expv >= 0) begin
            chk(req, "valid strobes", nv, 1);
            chk(req, "error strobes", ne, 0);
            chk(req, "code", int'(cmd_code), expv);
            model_code = expv;
        end else begin
            chk(req, "valid strobes", nv, 0);
            chk(req, "error strobes", ne, (expv == ERR) ? 1 : 0);
            chk({req, " R9"}, "held code", int'(cmd_code), model_code);
        end
    endtask

    task automatic frame(int nl, int ns, int lw, int sw, int gw);
        clear_mon();
        for (int i = 0; i < nl; i++) pulse(lw, gw);
        for (int i = 0; i < ns; i++) pulse(sw, gw);
        close_frame();
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R8", "valid in reset", int'(cmd_valid), 0);
        rst_n = 1'b1;
        drive(1'b0, 40 * DIV);
        chk("R8", "valid after reset", int'(cmd_valid), 0);
        chk("R8", "err after reset", int'(cmd_err), 0);
        chk("R8", "code after reset", int'(cmd_code), 0);
        chk("R8", "strobes while idle", nv + ne, 0);

        // R5: every legal command
        frame(4, 40, 15, 5, 5);  expect_frame("R5 back", 2);
        frame(4, 4, 15, 5, 5);   expect_frame("R5 stop", 0);
        frame(4, 10, 15, 5, 5);  expect_frame("R5 fwd", 1);
        frame(4, 58, 15, 5, 5);  expect_frame("R5 left", 3);
        frame(4, 64, 15, 5, 5);  expect_frame("R5 right", 4);

        // R6: counts that match nothing
        frame(4, 5, 15, 5, 5);   expect_frame("R6 count5", ERR);
        frame(4, 63, 15, 5, 5);  expect_frame("R6 count63", ERR);
        frame(4, 1, 15, 5, 5);   expect_frame("R6 count1", ERR);

        // R2: width limits
        frame(4, 10, 11, 3, 5);  expect_frame("R2 min widths", 1);
        frame(4, 4, 19, 7, 5);   expect_frame("R2 max widths", 0);
        frame(4, 10, 10, 5, 5);  expect_frame("R2 long too narrow", IGN);
        frame(4, 10, 20, 5, 5);  expect_frame("R2 long too wide", IGN);
        frame(4, 10, 15, 8, 5);  expect_frame("R2 short too wide", IGN);
        frame(4, 10, 15, 2, 5);  expect_frame("R2 short too narrow", IGN);

        // R3: preamble length
        frame(3, 10, 15, 5, 5);  expect_frame("R3 three longs", IGN);
        frame(5, 10, 15, 5, 5);  expect_frame("R3 five longs", IGN);

        // R10: long pulse inside the short run
        clear_mon();
        for (int i = 0; i < 4; i++) pulse(15, 5);
        for (int i = 0; i < 3; i++) pulse(5, 5);
        pulse(15, 5);
        pulse(5, 5);
        close_frame();
        expect_frame("R10 long in run", IGN);

        // R1: single-clock glitches inside gaps and pulses
        clear_mon();
        for (int i = 0; i < 4; i++) pulse_glitch(15, 5);
        for (int i = 0; i < 10; i++) pulse_glitch(5, 5);
        close_frame();
        expect_frame("R1 glitches", 1);

        // R4: long in-frame gaps survive, no early close
        clear_mon();
        for (int i = 0; i < 4; i++) pulse(15, 19);
        for (int i = 0; i < 3; i++) pulse(5, 19);
        drive(1'b1, 5 * DIV + DIV / 2);
        drive(1'b0, 15 * DIV);
        chk("R4", "strobes before timeout", nv + ne, 0);
        drive(1'b0, 15 * DIV);
        chk("R4", "valid after timeout", nv, 1);
        chk("R4", "code after timeout", int'(cmd_code), 0);
        model_code = 0;

        // Random frames, R5/R6
        for (int k = 0; k < 16; k++) begin
            int sel = $urandom_range(0, 9);
            int ns;
            int lw = $urandom_range(11, 19);
            int sw = $urandom_range(3, 7);
            int gw = $urandom_range(3, 12);
            case (sel)
                0: ns = 4;
                1: ns = 10;
                2: ns = 40;
                3: ns = 58;
                4: ns = 64;
                default: ns = $urandom_range(1, 66);
            endcase
            frame(4, ns, lw, sw, gw);
            expect_frame((exp_code(ns) >= 0) ? "R5 random" : "R6 random", exp_code(ns));
        end

        chk("R7", "valid and err together", n_both, 0);
        chk("R7", "valid longer than one cycle", n_run, 0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule